// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides, for one instruction bundle, whether a control transfer is taken and where it goes. It receives the control fields of the bundle's short syllable: a condition type, a prepared-target selector and a predicate source index. It also receives the value of the predicate that index names, the loop counters and the loop-valid flag. The condition type combines a predicate test with a loop-end term. Loop end is computed here from the epilogue counter, the loop counter and the loop-valid flag.

The predicate source index is passed straight to an outside predicate file, which returns the predicate value in the same cycle. The selector picks one of the prepared-target registers, and only the low address bits of that register are kept. All results are registered and appear one cycle after a valid strobe. A reserved condition type raises an illegal-encoding flag.

Top module: `branch_cond_eval`

## Requirements
- R1: After reset, `out_valid`, `taken`, `is_static`, `illegal` and `tgt_addr` are all zero.
- R2: Condition type 1 is always taken and sets `is_static`. Every other type leaves `is_static` clear.
- R3: Type 0 is never taken. Types 8 and 9 are reported as not taken. None of these three sets `illegal`.
- R4: Type 2 is taken when the predicate is 1. Type 3 is taken when the predicate is 0.
- R5: Loop end holds when the epilogue counter is zero, the loop counter is below 2 and `lc_valid` is 1. Type 4 is taken exactly on loop end and type 5 exactly when loop end does not hold.
- R6: Type 6 is taken on (predicate OR loop end). Type 14 is taken on (NOT predicate OR loop end).
- R7: Type 15 is taken on (predicate AND NOT loop end). Type 7 is taken on (NOT predicate AND NOT loop end).
- R8: Types 10 to 13 set `illegal` and are not taken. All other types leave `illegal` clear.
- R9: A nonzero `tsel_in` value k selects prepared register k, which sits at bits [k*REG_W-1:(k-1)*REG_W] of `tgt_regs`. `tgt_addr` is the low ADDR_W bits of that register. A zero selector gives a `tgt_addr` of zero.
- R10: Results appear one clock after `in_valid`, with `out_valid` high for that one cycle. While `in_valid` is low, `out_valid` is 0 and the other outputs hold their previous values.
- R11: `pred_idx` equals `psrc_in` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Syllable fields are valid this cycle |
| psrc_in | input | PSRC_W | Predicate source index field |
| ctype_in | input | 4 | Condition type field |
| tsel_in | input | SEL_W | Prepared-target selector field |
| pred_val | input | 1 | Value of the indexed predicate |
| loop_cnt | input | LCNT_W | Loop counter |
| epi_cnt | input | ECNT_W | Epilogue counter |
| lc_valid | input | 1 | Loop counter valid flag |
| tgt_regs | input | NUM_TGT*REG_W | Prepared-target registers, register 1 in the low word |
| pred_idx | output | PSRC_W | Index forwarded to the predicate file |
| out_valid | output | 1 | Result valid pulse |
| taken | output | 1 | Transfer taken |
| is_static | output | 1 | Unconditional (static) transfer |
| illegal | output | 1 | Reserved condition type seen |
| tgt_addr | output | ADDR_W | Selected target address |

## Verification
The bench builds the block with its default parameters: 32-bit counters, 64-bit prepared registers, a 48-bit address and a 2-bit selector, which gives three targets. With these values, every one of the sixteen condition codes can be driven against each of the three loop-end terms. Each selector value can be paired with register contents whose upper 16 bits are nonzero, so the truncation to 48 bits shows up at the output. The 32-bit loop counter also lets the bench apply a counter value far above 2, to confirm that loop end depends on the whole counter and not only its low bits.

// File: rtl/bce_pkg.sv
package bce_pkg;

   localparam int CT_W = 4;

   typedef enum logic [CT_W-1:0] {
      CT_NEVER      = 4'd0,
      CT_ALWAYS     = 4'd1,
      CT_PRED       = 4'd2,
      CT_NPRED      = 4'd3,
      CT_LEND       = 4'd4,
      CT_NLEND      = 4'd5,
      CT_PRED_OR_LE = 4'd6,
      CT_NP_AND_NLE = 4'd7,
      CT_LOCK       = 4'd8,
      CT_LOCK_CMP   = 4'd9,
      CT_RSV_A      = 4'd10,
      CT_RSV_B      = 4'd11,
      CT_RSV_C      = 4'd12,
      CT_RSV_D      = 4'd13,
      CT_NP_OR_LE   = 4'd14,
      CT_P_AND_NLE  = 4'd15
   } cond_type_e;

   typedef struct packed {
      logic taken;
      logic is_static;
      logic illegal;
   } cond_res_t;

endpackage

// File: rtl/bce_loop_end.sv
module bce_loop_end #(
   parameter int LCNT_W = 32,
   parameter int ECNT_W = 32
) (
   input  logic [LCNT_W-1:0] loop_cnt,
   input  logic [ECNT_W-1:0] epi_cnt,
   input  logic              lc_valid,
   output logic              loop_end
);
   localparam logic [LCNT_W-1:0] LAST_LIMIT = LCNT_W'(2);

   logic epi_done;
   logic last_iter;

   always_comb begin
      epi_done  = (epi_cnt == '0);
      last_iter = (loop_cnt < LAST_LIMIT) && lc_valid;
      loop_end  = epi_done && last_iter;
   end
endmodule

// File: rtl/bce_cond_decode.sv
module bce_cond_decode
   import bce_pkg::*;
(
   input  logic [CT_W-1:0] ctype,
   input  logic            pred,
   input  logic            loop_end,
   output cond_res_t       res
);
   cond_type_e ct;

   always_comb begin
      ct  = cond_type_e'(ctype);
      res = '0;
      unique case (ct)
         CT_NEVER:      res.taken = 1'b0;
         CT_ALWAYS:     begin res.taken = 1'b1; res.is_static = 1'b1; end
         CT_PRED:       res.taken = pred;
         CT_NPRED:      res.taken = ~pred;
         CT_LEND:       res.taken = loop_end;
         CT_NLEND:      res.taken = ~loop_end;
         CT_PRED_OR_LE: res.taken = pred | loop_end;
         CT_NP_AND_NLE: res.taken = ~pred & ~loop_end;
         CT_NP_OR_LE:   res.taken = ~pred | loop_end;
         CT_P_AND_NLE:  res.taken = pred & ~loop_end;
         CT_LOCK,
         CT_LOCK_CMP:   res.taken = 1'b0;
         CT_RSV_A,
         CT_RSV_B,
         CT_RSV_C,
         CT_RSV_D:      res.illegal = 1'b1;
         default:       res = '0;
      endcase
   end
endmodule

// File: rtl/bce_tgt_sel.sv
module bce_tgt_sel #(
   parameter int SEL_W  = 2,
   parameter int REG_W  = 64,
   parameter int ADDR_W = 48
) (
   input  logic [SEL_W-1:0]                 tsel,
   input  logic [((1<<SEL_W)-1)*REG_W-1:0]  tgt_regs,
   output logic [ADDR_W-1:0]                addr
);
   localparam int NUM_TGT = (1 << SEL_W) - 1;

   logic [ADDR_W-1:0] masked [NUM_TGT];

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_slot
      logic              hit;
      logic [REG_W-1:0]  word;
      assign hit  = (tsel == SEL_W'(i + 1));
      assign word = tgt_regs[i*REG_W +: REG_W];
      if (ADDR_W == REG_W) begin : g_full
         assign masked[i] = hit ? word : '0;
      end else begin : g_trunc
         assign masked[i] = hit ? word[ADDR_W-1:0] : '0;
      end
   end

   always_comb begin
      addr = '0;
      for (int i = 0; i < NUM_TGT; i++) begin
         addr = addr | masked[i];
      end
   end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
   import bce_pkg::*;
#(
   parameter int PSRC_W = 5,
   parameter int SEL_W  = 2,
   parameter int LCNT_W = 32,
   parameter int ECNT_W = 32,
   parameter int REG_W  = 64,
   parameter int ADDR_W = 48,
   localparam int NUM_TGT = (1 << SEL_W) - 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [PSRC_W-1:0]         psrc_in,
   input  logic [CT_W-1:0]           ctype_in,
   input  logic [SEL_W-1:0]          tsel_in,
   input  logic                      pred_val,
   input  logic [LCNT_W-1:0]         loop_cnt,
   input  logic [ECNT_W-1:0]         epi_cnt,
   input  logic                      lc_valid,
   input  logic [NUM_TGT*REG_W-1:0]  tgt_regs,
   output logic [PSRC_W-1:0]         pred_idx,
   output logic                      out_valid,
   output logic                      taken,
   output logic                      is_static,
   output logic                      illegal,
   output logic [ADDR_W-1:0]         tgt_addr
);
   if (ADDR_W > REG_W) begin : g_chk_addr
      $error("ADDR_W must not exceed REG_W");
   end
   if (SEL_W < 1) begin : g_chk_sel
      $error("SEL_W must be at least 1");
   end
   if (LCNT_W < 2) begin : g_chk_lcnt
      $error("LCNT_W must be at least 2");
   end

   logic              loop_end;
   cond_res_t         res;
   logic [ADDR_W-1:0] addr_nxt;

   assign pred_idx = psrc_in;

   bce_loop_end #(.LCNT_W(LCNT_W), .ECNT_W(ECNT_W)) u_lend (
      .loop_cnt (loop_cnt),
      .epi_cnt  (epi_cnt),
      .lc_valid (lc_valid),
      .loop_end (loop_end)
   );

   bce_cond_decode u_dec (
      .ctype    (ctype_in),
      .pred     (pred_val),
      .loop_end (loop_end),
      .res      (res)
   );

   bce_tgt_sel #(.SEL_W(SEL_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_tsel (
      .tsel     (tsel_in),
      .tgt_regs (tgt_regs),
      .addr     (addr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         taken     <= 1'b0;
         is_static <= 1'b0;
         illegal   <= 1'b0;
         tgt_addr  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            taken     <= res.taken;
            is_static <= res.is_static;
            illegal   <= res.illegal;
            tgt_addr  <= addr_nxt;
         end
      end
   end
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
   parameter int SEL_W  = 2,
   parameter int ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        ctype_in,
   input logic [SEL_W-1:0]  tsel_in,
   input logic              out_valid,
   input logic              taken,
   input logic              is_static,
   input logic              illegal,
   input logic [ADDR_W-1:0] tgt_addr
);
   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(taken) && $stable(tgt_addr) && $stable(illegal))); // R10
   AST_STATIC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctype_in == 4'd1) |=> (taken && is_static)); // R2
   AST_NEVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctype_in == 4'd0) |=> (!taken && !illegal && !is_static)); // R3
   AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctype_in >= 4'd10 && ctype_in <= 4'd13) |=> (illegal && !taken)); // R8
   AST_NO_SELECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && tsel_in == '0) |=> (tgt_addr == '0)); // R9
endmodule

bind branch_cond_eval bce_checker #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_branch_cond_eval.sv
`timescale 1ns/1ps
module sim_branch_cond_eval;
   localparam int PSRC_W = 5;
   localparam int SEL_W  = 2;
   localparam int LCNT_W = 32;
   localparam int ECNT_W = 32;
   localparam int REG_W  = 64;
   localparam int ADDR_W = 48;
   localparam int NUM_TGT = 3;

   // row: {ctype[11:8], pred[7], epi_nonzero[6], lc[5:4], lc_valid[3], exp_taken[2], exp_static[1], exp_illegal[0]}
   localparam int NV = 30;
   localparam logic [11:0] VEC [NV] = '{
      12'b0000_1_0_00_1_000, // R3 type 0
      12'b0001_0_1_11_0_110, // R2 type 1
      12'b0010_1_1_11_0_100, // R4
      12'b0010_0_0_00_1_000, // R4
      12'b0011_0_1_11_0_100, // R4
      12'b0011_1_0_00_1_000, // R4
      12'b0100_0_0_01_1_100, // R5 le
      12'b0100_1_0_10_1_000, // R5 lc=2
      12'b0100_1_1_00_1_000, // R5 epi!=0
      12'b0100_1_0_00_0_000, // R5 lcv=0
      12'b0101_0_0_01_1_000, // R5
      12'b0101_0_0_11_1_100, // R5
      12'b0110_0_0_00_1_100, // R6
      12'b0110_1_1_00_1_100, // R6
      12'b0110_0_1_00_1_000, // R6
      12'b1110_1_0_00_1_100, // R6
      12'b1110_1_1_00_1_000, // R6
      12'b1110_0_1_00_1_100, // R6
      12'b0111_0_1_00_1_100, // R7
      12'b0111_0_0_00_1_000, // R7
      12'b0111_1_1_00_1_000, // R7
      12'b1111_1_1_00_1_100, // R7
      12'b1111_1_0_01_1_000, // R7
      12'b1111_0_1_00_1_000, // R7
      12'b1000_1_0_00_1_000, // R3 type 8
      12'b1001_1_0_00_1_000, // R3 type 9
      12'b1010_1_0_00_1_001, // R8
      12'b1101_1_0_00_1_001, // R8
      12'b1011_0_1_11_0_001, // R8
      12'b1100_0_0_00_1_001  // R8
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [PSRC_W-1:0] psrc_in = '0;
   logic [3:0] ctype_in = '0;
   logic [SEL_W-1:0] tsel_in = '0;
   logic pred_val = 1'b0;
   logic [LCNT_W-1:0] loop_cnt = '0;
   logic [ECNT_W-1:0] epi_cnt = '0;
   logic lc_valid = 1'b0;
   logic [NUM_TGT*REG_W-1:0] tgt_regs;
   logic [PSRC_W-1:0] pred_idx;
   logic out_valid, taken, is_static, illegal;
   logic [ADDR_W-1:0] tgt_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   branch_cond_eval #(
      .PSRC_W(PSRC_W), .SEL_W(SEL_W), .LCNT_W(LCNT_W), .ECNT_W(ECNT_W),
      .REG_W(REG_W), .ADDR_W(ADDR_W)
   ) u0 (.*);

   function automatic logic [ADDR_W-1:0] exp_tgt(input logic [SEL_W-1:0] s);
      logic [REG_W-1:0] w;
      if (s == '0) return '0;
      w = tgt_regs[(int'(s)-1)*REG_W +: REG_W];
      return w[ADDR_W-1:0];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] ct, input logic p, input logic [ECNT_W-1:0] ec,
                        input logic [LCNT_W-1:0] lc, input logic lv, input logic [SEL_W-1:0] ts);
      @(negedge clk);
      in_valid = 1'b1; ctype_in = ct; pred_val = p; epi_cnt = ec;
      loop_cnt = lc; lc_valid = lv; tsel_in = ts;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tgt_regs = {64'hF00D_7777_8888_9999, 64'hBEEF_4444_5555_6666, 64'hDEAD_1111_2222_3333};
      repeat (3) @(posedge clk);
      #1;
      check("R1 out_valid", 64'(out_valid), 64'd0);
      check("R1 taken", 64'(taken), 64'd0);
      check("R1 static", 64'(is_static), 64'd0);
      check("R1 illegal", 64'(illegal), 64'd0);
      check("R1 tgt_addr", 64'(tgt_addr), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [11:0] v;
         logic [SEL_W-1:0] ts;
         v  = VEC[i];
         ts = SEL_W'(i % 4);
         issue(v[11:8], v[7], v[6] ? ECNT_W'(5) : '0, LCNT_W'(v[5:4]), v[3], ts);
         check($sformatf("R10 valid row %0d", i), 64'(out_valid), 64'd1);
         check($sformatf("R2-R8 taken row %0d", i), 64'(taken), 64'(v[2]));
         check($sformatf("R2 static row %0d", i), 64'(is_static), 64'(v[1]));
         check($sformatf("R8 illegal row %0d", i), 64'(illegal), 64'(v[0]));
         check($sformatf("R9 target row %0d", i), 64'(tgt_addr), 64'(exp_tgt(ts)));
      end

      // R5: large loop counter with zero epilogue is not loop end
      issue(4'd4, 1'b0, '0, 32'hFFFF_FFF0, 1'b1, 2'd3);
      check("R5 large loop_cnt type4", 64'(taken), 64'd0);
      check("R9 reg3 truncated", 64'(tgt_addr), 64'h7777_8888_9999);
      issue(4'd5, 1'b0, '0, 32'h0000_0100, 1'b1, 2'd1);
      check("R5 loop_cnt 256 type5", 64'(taken), 64'd1);

      // R10: hold while idle
      issue(4'd1, 1'b0, '0, '0, 1'b0, 2'd2);
      @(negedge clk);
      ctype_in = 4'd0; tsel_in = 2'd0; pred_val = 1'b0;
      @(posedge clk);
      #1;
      check("R10 idle out_valid", 64'(out_valid), 64'd0);
      check("R10 idle taken held", 64'(taken), 64'd1);
      check("R10 idle static held", 64'(is_static), 64'd1);
      check("R10 idle target held", 64'(tgt_addr), 64'h4444_5555_6666);

      // R11: index passthrough
      for (int k = 0; k < 32; k += 7) begin
         @(negedge clk);
         psrc_in = PSRC_W'(k);
         #1;
         check("R11 pred_idx", 64'(pred_idx), 64'(k));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule